// File: doc/BRIEF.md
# Single Load/Store Execution Unit

This unit carries out one single-register memory transfer for a 32-bit core with sixteen general registers. A decoded request names the access width, a flag that selects sign extension for sub-word loads and rotation for word loads, an indexing mode, a data register, a base register and a signed offset. When the request is accepted, the unit reads both registers through two combinational read ports. It forms the effective address and issues one access on a memory port with a valid/ready request and a response that carries read data and a data-abort flag.

Once the response arrives, the unit finishes in the next cycle. On that cycle it places the formatted load result on a destination write port and the updated base on a base write port. If a load targets register 15 (the program counter), the result goes out as a branch target instead of a register write. An abort cancels every register-side effect. Stores of register 15 send its value plus 4 to memory. Sub-word stores copy the source bits across the bus lanes and mark the lanes in use with byte enables.

Top module: `ldst_unit`

## Requirements
- R1: The access address is base plus offset for indexing modes none (code 0) and pre (code 1), and the unmodified base for mode post (code 2). `mem_we_o` is high for stores.
- R2: On completion without abort, modes pre and post write base plus offset to the base register. Mode none makes no base write.
- R3: When the response carries an abort, the completion cycle asserts no destination write, no base write and no branch. This holds for loads and stores.
- R4: A word load (size code 2) with the flag set returns the bus word rotated right by 8 times address bits 1:0. With the flag clear, the word is returned unrotated.
- R5: Byte (size code 0) and halfword (size code 1) loads take lane address[1:0] or halfword address[1] from the little-endian bus. They are sign-extended when the flag is set and zero-extended when it is clear.
- R6: A store whose data register is 15 drives the register value plus 4 on the bus.
- R7: A load into register 15 raises `br_valid_o` with the result as target and makes no destination write. Bit 0 of the target is cleared when `core_alt_i` or `cfg_clr_lsb_i` was high at acceptance.
- R8: Word stores drive the full value with enables 1111. Byte stores copy bits 7:0 into all four lanes and enable only lane address[1:0]. Halfword stores copy bits 15:0 into both halves and enable 0011 or 1100 by address[1].
- R9: From acceptance, `mem_req_valid_o` stays high with stable address, data and enables until `mem_req_ready_i`. `busy_o` stays high until completion. `done_o` pulses for exactly one cycle, the cycle after the response.
- R10: A load whose base and destination registers are equal writes the loaded value and suppresses the base write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present; taken when not busy |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_sgn_rot_i | input | 1 | Sign-extend sub-word loads / rotate word loads |
| req_wb_i | input | 2 | Indexing mode: 0 none, 1 pre, 2 post |
| req_rd_i | input | 4 | Data register index |
| req_rn_i | input | 4 | Base register index |
| req_offset_i | input | 32 | Signed offset |
| core_alt_i | input | 1 | Core variant: clear bit 0 of loaded branch targets |
| cfg_clr_lsb_i | input | 1 | Control bit: clear bit 0 of loaded branch targets |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion pulse |
| rf_base_addr_o | output | 4 | Register read index for base |
| rf_base_data_i | input | 32 | Base register value |
| rf_data_addr_o | output | 4 | Register read index for data |
| rf_data_data_i | input | 32 | Data register value |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | Write access |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Store data, lane-replicated |
| mem_be_o | output | 4 | Byte enables |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rdata_i | input | 32 | Read data |
| mem_abort_i | input | 1 | Data abort with the response |
| wr_dst_en_o | output | 1 | Destination register write |
| wr_dst_addr_o | output | 4 | Destination index |
| wr_dst_data_o | output | 32 | Destination value |
| wr_base_en_o | output | 1 | Base register write |
| wr_base_addr_o | output | 4 | Base index |
| wr_base_data_o | output | 32 | Updated base |
| br_valid_o | output | 1 | Branch request from a load into register 15 |
| br_target_o | output | 32 | Branch target |

## Verification
The properties assume a well-behaved memory port. It returns exactly one response per accepted request, only after the request handshake, and raises no response while the unit is idle or still requesting. The stimulus meets this by acting as that port itself. It answers each request one cycle after granting ready and keeps the response lines low otherwise. Requests use only the three defined indexing codes, and each is issued only while `busy_o` is low.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 16;
  localparam int RIDX_W = $clog2(NREG);
  localparam int NLANE  = XLEN / 8;
  localparam int LANE_W = $clog2(NLANE);
  localparam int SH_W   = LANE_W + 3;
  localparam logic [RIDX_W-1:0] PC_IDX       = RIDX_W'(NREG - 1);
  localparam logic [XLEN-1:0]   PC_STORE_ADJ = XLEN'(4);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    WB_NONE = 2'd0,
    WB_PRE  = 2'd1,
    WB_POST = 2'd2
  } wb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_FIN
  } ctl_state_e;

  typedef struct packed {
    logic              store;
    acc_size_e         size;
    logic              sgn_rot;
    wb_mode_e          wb;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rn;
    logic [XLEN-1:0]   base;
    logic [XLEN-1:0]   data;
    logic [XLEN-1:0]   offset;
  } op_t;
endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic mem_req_ready_i,
  input  logic mem_rsp_valid_i,
  output logic accept_o,
  output logic rsp_take_o,
  output logic mem_req_valid_o,
  output logic busy_o,
  output logic done_o
);
  ctl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i)     state_d = ST_REQ;
      ST_REQ:  if (mem_req_ready_i) state_d = ST_RSP;
      ST_RSP:  if (mem_rsp_valid_i) state_d = ST_FIN;
      ST_FIN:                       state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign accept_o        = (state_q == ST_IDLE) && req_valid_i;
  assign rsp_take_o      = (state_q == ST_RSP) && mem_rsp_valid_i;
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = (state_q == ST_FIN);
endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import ldst_pkg::*;
(
  input  acc_size_e         size_i,
  input  wb_mode_e          wb_i,
  input  logic [RIDX_W-1:0] rd_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   data_i,
  input  logic [XLEN-1:0]   offset_i,
  output logic [XLEN-1:0]   addr_o,
  output logic [XLEN-1:0]   new_base_o,
  output logic [XLEN-1:0]   wdata_o,
  output logic [NLANE-1:0]  be_o
);
  logic [XLEN-1:0]   sum;
  logic [XLEN-1:0]   src;
  logic [LANE_W-1:0] lane;

  assign sum        = base_i + offset_i;
  assign addr_o     = (wb_i == WB_POST) ? base_i : sum;
  assign new_base_o = sum;
  // reading the PC yields the instruction address plus a pipeline step
  assign src        = (rd_i == PC_IDX) ? data_i + PC_STORE_ADJ : data_i;
  assign lane       = addr_o[LANE_W-1:0];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [7:0] lane_d;
    logic       lane_en;
    always_comb begin
      unique case (size_i)
        SZ_BYTE: begin
          lane_d  = src[7:0];
          lane_en = (lane == LANE_W'(g));
        end
        SZ_HALF: begin
          lane_d  = src[8*(g%2) +: 8];
          lane_en = (lane[LANE_W-1:1] == (LANE_W-1)'(g/2));
        end
        default: begin
          lane_d  = src[8*g +: 8];
          lane_en = 1'b1;
        end
      endcase
    end
    assign wdata_o[8*g +: 8] = lane_d;
    assign be_o[g]           = lane_en;
  end
endmodule

// File: rtl/ldst_load_fmt.sv
module ldst_load_fmt
  import ldst_pkg::*;
(
  input  acc_size_e         size_i,
  input  logic              sgn_rot_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [XLEN-1:0]   rdata_i,
  output logic [XLEN-1:0]   value_o
);
  logic [SH_W-1:0]  sh;
  logic [SH_W:0]    sh_inv;
  logic [XLEN-1:0]  rot;
  logic [7:0]       b;
  logic [15:0]      h;

  assign sh     = {lane_i, 3'b000};
  assign sh_inv = (SH_W+1)'(XLEN) - {1'b0, sh};
  assign rot    = (rdata_i >> sh) | (rdata_i << sh_inv);
  assign b      = rdata_i[sh +: 8];
  assign h      = rdata_i[{lane_i[LANE_W-1], 4'b0000} +: 16];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: value_o = sgn_rot_i ? {{(XLEN-8){b[7]}}, b}   : {{(XLEN-8){1'b0}}, b};
      SZ_HALF: value_o = sgn_rot_i ? {{(XLEN-16){h[15]}}, h} : {{(XLEN-16){1'b0}}, h};
      default: value_o = sgn_rot_i ? rot : rdata_i;
    endcase
  end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_sgn_rot_i,
  input  logic [1:0]        req_wb_i,
  input  logic [RIDX_W-1:0] req_rd_i,
  input  logic [RIDX_W-1:0] req_rn_i,
  input  logic [XLEN-1:0]   req_offset_i,
  input  logic              core_alt_i,
  input  logic              cfg_clr_lsb_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [RIDX_W-1:0] rf_base_addr_o,
  input  logic [XLEN-1:0]   rf_base_data_i,
  output logic [RIDX_W-1:0] rf_data_addr_o,
  input  logic [XLEN-1:0]   rf_data_data_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_we_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  output logic [NLANE-1:0]  mem_be_o,
  input  logic              mem_rsp_valid_i,
  input  logic [XLEN-1:0]   mem_rdata_i,
  input  logic              mem_abort_i,
  output logic              wr_dst_en_o,
  output logic [RIDX_W-1:0] wr_dst_addr_o,
  output logic [XLEN-1:0]   wr_dst_data_o,
  output logic              wr_base_en_o,
  output logic [RIDX_W-1:0] wr_base_addr_o,
  output logic [XLEN-1:0]   wr_base_data_o,
  output logic              br_valid_o,
  output logic [XLEN-1:0]   br_target_o
);
  op_t             op_q;
  logic            clr_q;
  logic [XLEN-1:0] rdata_q;
  logic            abort_q;
  logic            accept;
  logic            rsp_take;
  logic [XLEN-1:0] new_base;
  logic [XLEN-1:0] ld_val;
  logic            is_load;
  logic            ok;
  logic            load_to_pc;

  ldst_ctrl u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .accept_o        (accept),
    .rsp_take_o      (rsp_take),
    .mem_req_valid_o (mem_req_valid_o),
    .busy_o          (busy_o),
    .done_o          (done_o)
  );

  assign rf_base_addr_o = req_rn_i;
  assign rf_data_addr_o = req_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      clr_q   <= 1'b0;
      rdata_q <= '0;
      abort_q <= 1'b0;
    end else begin
      if (accept) begin
        op_q <= '{store:   req_store_i,
                  size:    acc_size_e'(req_size_i),
                  sgn_rot: req_sgn_rot_i,
                  wb:      wb_mode_e'(req_wb_i),
                  rd:      req_rd_i,
                  rn:      req_rn_i,
                  base:    rf_base_data_i,
                  data:    rf_data_data_i,
                  offset:  req_offset_i};
        clr_q <= core_alt_i | cfg_clr_lsb_i;
      end
      if (rsp_take) begin
        rdata_q <= mem_rdata_i;
        abort_q <= mem_abort_i;
      end
    end
  end

  ldst_addr_gen u_agen (
    .size_i     (op_q.size),
    .wb_i       (op_q.wb),
    .rd_i       (op_q.rd),
    .base_i     (op_q.base),
    .data_i     (op_q.data),
    .offset_i   (op_q.offset),
    .addr_o     (mem_addr_o),
    .new_base_o (new_base),
    .wdata_o    (mem_wdata_o),
    .be_o       (mem_be_o)
  );

  ldst_load_fmt u_fmt (
    .size_i    (op_q.size),
    .sgn_rot_i (op_q.sgn_rot),
    .lane_i    (mem_addr_o[LANE_W-1:0]),
    .rdata_i   (rdata_q),
    .value_o   (ld_val)
  );

  assign mem_we_o   = op_q.store;
  assign is_load    = !op_q.store;
  assign ok         = done_o && !abort_q;
  assign load_to_pc = is_load && (op_q.rd == PC_IDX);

  assign wr_dst_en_o    = ok && is_load && !load_to_pc;
  assign wr_dst_addr_o  = op_q.rd;
  assign wr_dst_data_o  = ld_val;
  // on a base/destination collision the loaded value wins
  assign wr_base_en_o   = ok && (op_q.wb != WB_NONE) && !(is_load && (op_q.rn == op_q.rd));
  assign wr_base_addr_o = op_q.rn;
  assign wr_base_data_o = new_base;
  assign br_valid_o     = ok && load_to_pc;
  assign br_target_o    = clr_q ? {ld_val[XLEN-1:1], 1'b0} : ld_val;
endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk
  import ldst_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              busy_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [XLEN-1:0]   mem_addr_o,
  input logic [XLEN-1:0]   mem_wdata_o,
  input logic [NLANE-1:0]  mem_be_o,
  input logic              mem_rsp_valid_i,
  input logic              mem_abort_i,
  input logic              wr_dst_en_o,
  input logic [RIDX_W-1:0] wr_dst_addr_o,
  input logic              wr_base_en_o,
  input logic [RIDX_W-1:0] wr_base_addr_o,
  input logic              br_valid_o
);
  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o)
      && $stable(mem_wdata_o) && $stable(mem_be_o));

  a_r9_done_after_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_rsp_valid_i));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_busy_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r3_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && $past(mem_rsp_valid_i && mem_abort_i) |-> !wr_dst_en_o && !wr_base_en_o && !br_valid_o);

  a_r2_writes_only_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dst_en_o || wr_base_en_o || br_valid_o) |-> done_o);

  a_r7_branch_no_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_o |-> !wr_dst_en_o);

  a_r10_no_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dst_en_o && wr_base_en_o |-> wr_dst_addr_o != wr_base_addr_o);

  a_r8_be_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2
      || $countones(mem_be_o) == 4));
endmodule

bind ldst_unit ldst_unit_chk u_chk (.*);

// File: tb/ldst_unit_test.sv
module ldst_unit_test;
  import ldst_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid_i = 1'b0, req_store_i = 1'b0, req_sgn_rot_i = 1'b0;
  logic [1:0]  req_size_i = 2'd0, req_wb_i = 2'd0;
  logic [3:0]  req_rd_i = 4'd0, req_rn_i = 4'd0;
  logic [31:0] req_offset_i = 32'd0;
  logic        core_alt_i = 1'b0, cfg_clr_lsb_i = 1'b0;
  logic        busy_o, done_o;
  logic [3:0]  rf_base_addr_o, rf_data_addr_o;
  logic [31:0] rf_base_data_i, rf_data_data_i;
  logic        mem_req_valid_o, mem_we_o;
  logic        mem_req_ready_i = 1'b0, mem_rsp_valid_i = 1'b0, mem_abort_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = 32'd0;
  logic [3:0]  mem_be_o;
  logic        wr_dst_en_o, wr_base_en_o, br_valid_o;
  logic [3:0]  wr_dst_addr_o, wr_base_addr_o;
  logic [31:0] wr_dst_data_o, wr_base_data_o, br_target_o;

  logic [31:0] regs [16];
  assign rf_base_data_i = regs[rf_base_addr_o];
  assign rf_data_data_i = regs[rf_data_addr_o];

  ldst_unit uut (.clk_i(clk), .*);

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic st; logic [1:0] sz; logic sr; logic [1:0] wb; logic [3:0] rd; logic [3:0] rn;
    logic [31:0] base; logic [31:0] data; logic [31:0] off; logic [31:0] rdata;
    logic abt; logic alt; logic c15;
    logic [31:0] e_addr; logic [31:0] e_wdata; logic [3:0] e_be;
    logic e_dst; logic e_br; logic e_bwr; logic [31:0] e_val; logic [31:0] e_base;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // 0 R1: word load, no writeback
    '{1'b0,2'd2,1'b1,2'd0,4'd1,4'd2,32'h1000,32'h0,32'h4,32'h11223344,1'b0,1'b0,1'b0,
      32'h1004,32'h0,4'hF,1'b1,1'b0,1'b0,32'h11223344,32'h0},
    // 1 R4: rotate by one lane, pre
    '{1'b0,2'd2,1'b1,2'd1,4'd3,4'd4,32'h2000,32'h0,32'h1,32'h11223344,1'b0,1'b0,1'b0,
      32'h2001,32'h0,4'hF,1'b1,1'b0,1'b1,32'h44112233,32'h2001},
    // 2 R2: post, rotate by three lanes
    '{1'b0,2'd2,1'b1,2'd2,4'd5,4'd6,32'h3003,32'h0,32'h10,32'h11223344,1'b0,1'b0,1'b0,
      32'h3003,32'h0,4'hF,1'b1,1'b0,1'b1,32'h22334411,32'h3013},
    // 3 R4: no rotate when flag clear
    '{1'b0,2'd2,1'b0,2'd0,4'd1,4'd2,32'h4000,32'h0,32'h2,32'h11223344,1'b0,1'b0,1'b0,
      32'h4002,32'h0,4'hF,1'b1,1'b0,1'b0,32'h11223344,32'h0},
    // 4 R5: signed byte lane 1
    '{1'b0,2'd0,1'b1,2'd0,4'd1,4'd2,32'h100,32'h0,32'h1,32'h00008000,1'b0,1'b0,1'b0,
      32'h101,32'h0,4'h2,1'b1,1'b0,1'b0,32'hFFFFFF80,32'h0},
    // 5 R5: unsigned byte lane 3, pre
    '{1'b0,2'd0,1'b0,2'd1,4'd1,4'd2,32'h100,32'h0,32'h3,32'hF0000000,1'b0,1'b0,1'b0,
      32'h103,32'h0,4'h8,1'b1,1'b0,1'b1,32'h000000F0,32'h103},
    // 6 R5: signed upper half
    '{1'b0,2'd1,1'b1,2'd0,4'd1,4'd2,32'h200,32'h0,32'h2,32'h80011234,1'b0,1'b0,1'b0,
      32'h202,32'h0,4'hC,1'b1,1'b0,1'b0,32'hFFFF8001,32'h0},
    // 7 R5: unsigned lower half, post with negative offset
    '{1'b0,2'd1,1'b0,2'd2,4'd1,4'd2,32'h300,32'h0,32'hFFFFFFFC,32'hABCD9876,1'b0,1'b0,1'b0,
      32'h300,32'h0,4'h3,1'b1,1'b0,1'b1,32'h00009876,32'h2FC},
    // 8 R8: word store
    '{1'b1,2'd2,1'b0,2'd0,4'd7,4'd8,32'h500,32'hCAFEBABE,32'h8,32'h0,1'b0,1'b0,1'b0,
      32'h508,32'hCAFEBABE,4'hF,1'b0,1'b0,1'b0,32'h0,32'h0},
    // 9 R8: byte store lane 2, pre
    '{1'b1,2'd0,1'b0,2'd1,4'd9,4'd8,32'h600,32'h12345678,32'h2,32'h0,1'b0,1'b0,1'b0,
      32'h602,32'h78787878,4'h4,1'b0,1'b0,1'b1,32'h0,32'h602},
    // 10 R8: half store low, post
    '{1'b1,2'd1,1'b0,2'd2,4'd10,4'd8,32'h700,32'hDEAD5A5A,32'h6,32'h0,1'b0,1'b0,1'b0,
      32'h700,32'h5A5A5A5A,4'h3,1'b0,1'b0,1'b1,32'h0,32'h706},
    // 11 R8: half store high
    '{1'b1,2'd1,1'b0,2'd0,4'd10,4'd8,32'h702,32'h0000BEEF,32'h0,32'h0,1'b0,1'b0,1'b0,
      32'h702,32'hBEEFBEEF,4'hC,1'b0,1'b0,1'b0,32'h0,32'h0},
    // 12 R6: store of register 15
    '{1'b1,2'd2,1'b0,2'd0,4'd15,4'd8,32'h800,32'h8000,32'h0,32'h0,1'b0,1'b0,1'b0,
      32'h800,32'h8004,4'hF,1'b0,1'b0,1'b0,32'h0,32'h0},
    // 13 R7: branch keeps bit 0
    '{1'b0,2'd2,1'b1,2'd0,4'd15,4'd2,32'h900,32'h0,32'h0,32'h2001,1'b0,1'b0,1'b0,
      32'h900,32'h0,4'hF,1'b0,1'b1,1'b0,32'h2001,32'h0},
    // 14 R7: variant clears bit 0
    '{1'b0,2'd2,1'b1,2'd0,4'd15,4'd2,32'h900,32'h0,32'h0,32'h2001,1'b0,1'b1,1'b0,
      32'h900,32'h0,4'hF,1'b0,1'b1,1'b0,32'h2000,32'h0},
    // 15 R7: control bit clears bit 0
    '{1'b0,2'd2,1'b1,2'd0,4'd15,4'd2,32'h900,32'h0,32'h0,32'h2001,1'b0,1'b0,1'b1,
      32'h900,32'h0,4'hF,1'b0,1'b1,1'b0,32'h2000,32'h0},
    // 16 R3: aborted load, pre
    '{1'b0,2'd2,1'b1,2'd1,4'd1,4'd2,32'h1000,32'h0,32'h4,32'hFFFF,1'b1,1'b0,1'b0,
      32'h1004,32'h0,4'hF,1'b0,1'b0,1'b0,32'h0,32'h0},
    // 17 R10: load with base == destination
    '{1'b0,2'd2,1'b1,2'd1,4'd4,4'd4,32'h1000,32'h0,32'h4,32'h55,1'b0,1'b0,1'b0,
      32'h1004,32'h0,4'hF,1'b1,1'b0,1'b0,32'h55,32'h0},
    // 18 R3: aborted store, post
    '{1'b1,2'd2,1'b0,2'd2,4'd7,4'd8,32'h500,32'h1,32'h4,32'h0,1'b1,1'b0,1'b0,
      32'h500,32'h1,4'hF,1'b0,1'b0,1'b0,32'h0,32'h0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0:             return "R1";
      1, 3:          return "R4";
      2:             return "R2";
      4, 5, 6, 7:    return "R5";
      8, 9, 10, 11:  return "R8";
      12:            return "R6";
      13, 14, 15:    return "R7";
      16, 18:        return "R3";
      default:       return "R10";
    endcase
  endfunction

  task automatic ceq(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input string tag, input int stall);
    @(negedge clk);
    regs[v.rd] = v.data;
    regs[v.rn] = v.base;
    req_store_i = v.st; req_size_i = v.sz; req_sgn_rot_i = v.sr; req_wb_i = v.wb;
    req_rd_i = v.rd; req_rn_i = v.rn; req_offset_i = v.off;
    core_alt_i = v.alt; cfg_clr_lsb_i = v.c15;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    core_alt_i = 1'b0; cfg_clr_lsb_i = 1'b0;
    for (int k = 0; k < stall; k++) begin
      ceq("R9", "req held", 32'(mem_req_valid_o), 32'd1);
      ceq("R9", "busy while stalled", 32'(busy_o), 32'd1);
      ceq("R9", "addr stable", mem_addr_o, v.e_addr);
      @(negedge clk);
    end
    ceq("R9", "req valid", 32'(mem_req_valid_o), 32'd1);
    ceq("R1", "address", mem_addr_o, v.e_addr);
    ceq("R1", "write flag", 32'(mem_we_o), 32'(v.st));
    if (v.st) begin
      ceq(tag, "store data", mem_wdata_o, v.e_wdata);
      ceq(tag, "byte enables", 32'(mem_be_o), 32'(v.e_be));
    end
    mem_req_ready_i = 1'b1;
    @(negedge clk);
    mem_req_ready_i = 1'b0;
    ceq("R9", "req dropped", 32'(mem_req_valid_o), 32'd0);
    ceq("R9", "no early done", 32'(done_o), 32'd0);
    mem_rsp_valid_i = 1'b1; mem_rdata_i = v.rdata; mem_abort_i = v.abt;
    @(negedge clk);
    mem_rsp_valid_i = 1'b0; mem_abort_i = 1'b0; mem_rdata_i = 32'h0;
    ceq("R9", "done", 32'(done_o), 32'd1);
    ceq("R9", "busy at done", 32'(busy_o), 32'd1);
    ceq(tag, "dst write", 32'(wr_dst_en_o), 32'(v.e_dst));
    if (v.e_dst) begin
      ceq(tag, "dst index", 32'(wr_dst_addr_o), 32'(v.rd));
      ceq(tag, "dst value", wr_dst_data_o, v.e_val);
    end
    ceq(tag, "branch", 32'(br_valid_o), 32'(v.e_br));
    if (v.e_br) ceq(tag, "branch target", br_target_o, v.e_val);
    ceq(tag, "base write", 32'(wr_base_en_o), 32'(v.e_bwr));
    if (v.e_bwr) begin
      ceq(tag, "base index", 32'(wr_base_addr_o), 32'(v.rn));
      ceq(tag, "base value", wr_base_data_o, v.e_base);
    end
    @(negedge clk);
    ceq("R9", "done single pulse", 32'(done_o), 32'd0);
    ceq("R9", "idle after done", 32'(busy_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h0;
    repeat (3) @(negedge clk);
    // reset state (R9)
    ceq("R9", "reset busy", 32'(busy_o), 32'd0);
    ceq("R9", "reset done", 32'(done_o), 32'd0);
    ceq("R9", "reset mem req", 32'(mem_req_valid_o), 32'd0);
    ceq("R3", "reset writes", 32'({wr_dst_en_o, wr_base_en_o, br_valid_o}), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], tag_of(i), 0);

    // R9: ready held off for several cycles
    run_vec(VECS[9], "R9", 3);
    run_vec(VECS[2], "R9", 2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule